// File: doc/BRIEF.md
# Indirect Control and Status Register File for a Network Controller

This block is the host-side register front end of a network controller. The host reaches it through a single 16-bit port with a one-bit port selector. With the selector at 1, the port holds the number of the register to access. With the selector at 0, the port reads or writes that register. Reads have no side effects. Register 0 is the command/status word. It combines command bits that act on a write of 1, read-only run indicators, a read/write interrupt enable, and event flags that are cleared by writing 1.

The block also holds the configuration registers. Registers 1 and 2 hold the two halves of the init-block address. Register 3 holds three bus-configuration bits. Registers 8 to 11 are the four multicast filter words. Register 15 is a mode word whose bit 15 enables promiscuous reception. Event pulses from the receive and transmit engines set the flags, and the block raises an interrupt line when a flag is set and interrupts are enabled.

The run control is a four-state machine:
- **STOPPED** is the reset state. It goes to INITIALIZING on the *init command* and to RUNNING on the *start command*.
- **INITIALIZING** goes to RUNNING on *init done with start pending*, or to IDLE on *init done without start*.
- **IDLE** goes to INITIALIZING on the *init command* and to RUNNING on the *start command*.
- **RUNNING** goes to INITIALIZING on the *init command*.
- A *stop command* takes any state to STOPPED, and it wins over every other transition.

Top module: `lan_csr_file`

## Requirements
- R1: A write with `reg_sel`=1 stores `reg_wdata[3:0]` as the selected register number. A read with `reg_sel`=1 returns that number in bits 3:0, with zeros above it. Reads never change any state.
- R2: After reset the state is STOPPED. Register 0 reads 0x0004, every other register reads 0, and `irq`, `tx_on`, `rx_on`, `tx_poll` and `init_start` are low.
- R3: Writing register 0 with bit 2 (stop) set enters STOPPED. Stop wins over init (bit 0) and start (bit 1) written in the same word. In STOPPED, register 0 shows bit 2 set and bits 0, 1, 4 and 5 clear. So with no flags set and interrupt enable clear, writing 0x0005 reads back as exactly 0x0004.
- R4: A stop command clears register 3 (bit 0 byte control, bit 1 address-strobe control, bit 2 byte swap) to 0. `bus_cfg` follows it.
- R5: Writing bit 0 (init) without stop, from STOPPED, IDLE or RUNNING, enters INITIALIZING. Register 0 then shows bit 0, and `init_start` pulses for one cycle. A start bit written together with init, or during INITIALIZING, sets start pending, which shows as bit 1. `evt_init_done` in INITIALIZING sets the init-done flag (bit 8), clears bit 0, and moves to RUNNING if start is pending, otherwise to IDLE. `evt_init_done` in any other state is ignored.
- R6: Writing bit 1 (start) without stop or init, in STOPPED or IDLE, enters RUNNING. In RUNNING, bits 1, 4 (transmitter on) and 5 (receiver on) read 1 and bit 2 reads 0, and `tx_on` and `rx_on` are high.
- R7: Writing bit 3 (transmit demand) without stop while RUNNING gives a one-cycle `tx_poll` pulse in the cycle after the write. Bit 3 always reads 0. In any other state the demand is ignored.
- R8: Writing 0 to command bits 0 to 3 has no effect. Writes to bits 4, 5 and 7 are ignored.
- R9: Event inputs set flags in register 0: transmit done sets bit 9, receive done bit 10, memory error bit 11, missed frame bit 12, carrier loss bit 13, babble bit 14. Writing 1 to bits 8 to 14 clears those flags. Writing 1 to bit 15 clears bits 11 to 14. An event that arrives in the same cycle as a clear leaves its flag set.
- R10: Bit 15 reads as the OR of bits 11 to 14. Bit 7 reads as the OR of bits 8 to 12 and bit 14 (carrier loss excluded).
- R11: Bit 6 is a plain read/write interrupt enable, written by every register 0 write. `irq` equals bit 7 AND bit 6.
- R12: Registers 1, 2, 3, 8 to 11 and 15 take writes only in STOPPED. Writes to them in other states, and writes to unused numbers, are ignored. `init_addr` = {reg2, reg1}, `bus_cfg` = reg3[2:0] (its upper bits read 0), `mc_filter` = {reg11, reg10, reg9, reg8}, and `promisc` = reg15[15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 1 = register-number port, 0 = data port |
| reg_wr | input | 1 | Write strobe for the selected port |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected port |
| evt_init_done | input | 1 | Init-block fetch finished |
| evt_tx_done | input | 1 | Transmit descriptor completed |
| evt_rx_done | input | 1 | Receive descriptor completed |
| evt_mem_err | input | 1 | Memory access error |
| evt_rx_missed | input | 1 | Frame dropped for lack of a buffer |
| evt_carrier_lost | input | 1 | Carrier/heartbeat error |
| evt_babble | input | 1 | Transmitter babble |
| irq | output | 1 | Interrupt request |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| init_start | output | 1 | One-cycle request to fetch the init block |
| tx_poll | output | 1 | One-cycle transmit demand |
| init_addr | output | 32 | Init-block address |
| bus_cfg | output | 3 | Bus configuration bits |
| mc_filter | output | 64 | Multicast filter |
| promisc | output | 1 | Promiscuous enable |

## Verification
A wrong run state shows at once, in the first cycle after the write. Register 0 shows it in its command and run bits and `tx_on`/`rx_on` follow it, while a lost transition shows as a missing `init_start` or `tx_poll` pulse one cycle after the command. A wrong flag shows in the next read of register 0, and in `irq` as soon as interrupt enable is set. A wrong lock on the configuration registers shows in the configuration outputs at the edge after a write made outside STOPPED.

// File: rtl/lcsr_pkg.sv
package lcsr_pkg;

    typedef enum logic [1:0] {
        CS_STOPPED      = 2'd0,
        CS_INITIALIZING = 2'd1,
        CS_IDLE         = 2'd2,
        CS_RUNNING      = 2'd3
    } ctl_state_e;

    // command/status word bit positions
    localparam int B_INIT = 0;
    localparam int B_STRT = 1;
    localparam int B_STOP = 2;
    localparam int B_TDMD = 3;
    localparam int B_TXON = 4;
    localparam int B_RXON = 5;
    localparam int B_INEA = 6;
    localparam int B_INTR = 7;
    localparam int B_FLG0 = 8;
    localparam int B_ERR  = 15;

    // event flag vector: index k maps to word bit B_FLG0+k
    localparam int NUM_EVT = 7;
    localparam logic [NUM_EVT-1:0] ERR_GROUP  = 7'b1111000; // mem, miss, carrier, babble
    localparam logic [NUM_EVT-1:0] INTR_GROUP = 7'b1011111; // all but carrier

endpackage

// File: rtl/lcsr_ctl_fsm.sv
module lcsr_ctl_fsm
    import lcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [3:0] cmd_bits,
    input  logic       init_done_in,
    output ctl_state_e state_q,
    output logic       start_pend_q,
    output logic       init_start_q,
    output logic       tx_poll_q,
    output logic       idon_set,
    output logic       stop_cmd
);

    ctl_state_e state_d;
    logic       pend_d;
    logic       init_wr;
    logic       strt_wr;
    logic       tdmd_wr;

    always_comb begin
        stop_cmd = cmd_wr & cmd_bits[B_STOP];
        init_wr  = cmd_wr & cmd_bits[B_INIT];
        strt_wr  = cmd_wr & cmd_bits[B_STRT];
        tdmd_wr  = cmd_wr & cmd_bits[B_TDMD];
        state_d  = state_q;
        pend_d   = start_pend_q;
        idon_set = 1'b0;
        if (stop_cmd) begin
            state_d = CS_STOPPED;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                CS_INITIALIZING: begin
                    if (init_done_in) begin
                        idon_set = 1'b1;
                        state_d  = (start_pend_q | strt_wr) ? CS_RUNNING : CS_IDLE;
                        pend_d   = 1'b0;
                    end else if (strt_wr) begin
                        pend_d = 1'b1;
                    end
                end
                CS_STOPPED, CS_IDLE: begin
                    if (init_wr) begin
                        state_d = CS_INITIALIZING;
                        pend_d  = strt_wr;
                    end else if (strt_wr) begin
                        state_d = CS_RUNNING;
                    end
                end
                CS_RUNNING: begin
                    if (init_wr) begin
                        state_d = CS_INITIALIZING;
                        pend_d  = strt_wr;
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= CS_STOPPED;
            start_pend_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            start_pend_q <= pend_d;
        end
    end

    // registered command pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_start_q <= 1'b0;
            tx_poll_q    <= 1'b0;
        end else begin
            init_start_q <= (state_d == CS_INITIALIZING) && (state_q != CS_INITIALIZING);
            tx_poll_q    <= tdmd_wr && !stop_cmd && (state_q == CS_RUNNING);
        end
    end

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_bits[B_STOP]) |=> (state_q == CS_STOPPED)); // R3
    AST_POLL_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_q |-> ($past(state_q) == CS_RUNNING)); // R7
    AST_INIT_PULSE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        init_start_q |-> (state_q == CS_INITIALIZING)); // R5
    AST_PEND_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        start_pend_q |-> (state_q == CS_INITIALIZING)); // R5

endmodule

// File: rtl/lcsr_evt_flags.sv
module lcsr_evt_flags
    import lcsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr0_wr,
    input  logic [15:0]        wdata,
    input  logic [NUM_EVT-1:0] evt_set,
    output logic [NUM_EVT-1:0] flg_q,
    output logic               inea_q,
    output logic               intr,
    output logic               err,
    output logic               irq
);

    logic [NUM_EVT-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (csr0_wr) begin
            clr_mask = wdata[B_FLG0 +: NUM_EVT];
            if (wdata[B_ERR]) clr_mask = clr_mask | ERR_GROUP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q  <= '0;
            inea_q <= 1'b0;
        end else begin
            flg_q <= (flg_q & ~clr_mask) | evt_set;
            if (csr0_wr) inea_q <= wdata[B_INEA];
        end
    end

    always_comb begin
        err  = |(flg_q & ERR_GROUP);
        intr = |(flg_q & INTR_GROUP);
        irq  = intr & inea_q;
    end

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((flg_q & $past(evt_set)) == $past(evt_set))); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr0_wr && evt_set == '0 && clr_mask != '0) |=> ((flg_q & $past(clr_mask)) == '0)); // R9
    AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        csr0_wr |=> (inea_q == $past(wdata[B_INEA]))); // R11

endmodule

// File: rtl/lcsr_cfg_regs.sv
module lcsr_cfg_regs #(
    parameter int DW        = 16,
    parameter int AW        = 4,
    parameter int NUM_FILT  = 4,
    parameter int FILT_BASE = 8,
    parameter int CFG_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          idx,
    input  logic [DW-1:0]          wdata,
    input  logic                   stop_cmd,
    output logic [2*DW-1:0]        init_addr,
    output logic [CFG_W-1:0]       bus_cfg,
    output logic [NUM_FILT*DW-1:0] filt,
    output logic [DW-1:0]          mode,
    output logic [DW-1:0]          rd_val
);

    localparam logic [AW-1:0] IDX_ALO  = AW'(1);
    localparam logic [AW-1:0] IDX_AHI  = AW'(2);
    localparam logic [AW-1:0] IDX_CFG  = AW'(3);
    localparam logic [AW-1:0] IDX_MODE = AW'((1 << AW) - 1);

    logic [DW-1:0]    alo_q;
    logic [DW-1:0]    ahi_q;
    logic [CFG_W-1:0] cfg_q;
    logic [DW-1:0]    mode_q;
    logic [DW-1:0]    filt_q [NUM_FILT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alo_q  <= '0;
            ahi_q  <= '0;
            cfg_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_en && idx == IDX_ALO)  alo_q  <= wdata;
            if (wr_en && idx == IDX_AHI)  ahi_q  <= wdata;
            if (wr_en && idx == IDX_MODE) mode_q <= wdata;
            if (stop_cmd)                      cfg_q <= '0;
            else if (wr_en && idx == IDX_CFG)  cfg_q <= wdata[CFG_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
        always_ff @(posedge clk) begin
            if (!rst_n)                                  filt_q[g] <= '0;
            else if (wr_en && idx == AW'(FILT_BASE + g)) filt_q[g] <= wdata;
        end
        assign filt[g*DW +: DW] = filt_q[g];
    end

    always_comb begin
        rd_val = '0;
        if (idx == IDX_ALO)  rd_val = alo_q;
        if (idx == IDX_AHI)  rd_val = ahi_q;
        if (idx == IDX_CFG)  rd_val = DW'(cfg_q);
        if (idx == IDX_MODE) rd_val = mode_q;
        for (int k = 0; k < NUM_FILT; k++) begin
            if (idx == AW'(FILT_BASE + k)) rd_val = filt_q[k];
        end
    end

    assign init_addr = {ahi_q, alo_q};
    assign bus_cfg   = cfg_q;
    assign mode      = mode_q;

    AST_CFG_CLEARED_BY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (bus_cfg == '0)); // R4
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !stop_cmd) |=> ($stable(init_addr) && $stable(filt) && $stable(mode) && $stable(bus_cfg))); // R12

endmodule

// File: rtl/lan_csr_file.sv
module lan_csr_file
    import lcsr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 4,
    parameter int NUM_FILT  = 4,
    parameter int FILT_BASE = 8,
    parameter int CFG_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_sel,
    input  logic                   reg_wr,
    input  logic [DW-1:0]          reg_wdata,
    output logic [DW-1:0]          reg_rdata,
    input  logic                   evt_init_done,
    input  logic                   evt_tx_done,
    input  logic                   evt_rx_done,
    input  logic                   evt_mem_err,
    input  logic                   evt_rx_missed,
    input  logic                   evt_carrier_lost,
    input  logic                   evt_babble,
    output logic                   irq,
    output logic                   tx_on,
    output logic                   rx_on,
    output logic                   init_start,
    output logic                   tx_poll,
    output logic [2*DW-1:0]        init_addr,
    output logic [CFG_W-1:0]       bus_cfg,
    output logic [NUM_FILT*DW-1:0] mc_filter,
    output logic                   promisc
);

    logic [AW-1:0]      sel_q;
    logic               data_wr;
    logic               csr0_wr;
    logic               cfg_wr;
    ctl_state_e         state_q;
    logic               start_pend;
    logic               idon_set;
    logic               stop_cmd;
    logic [NUM_EVT-1:0] evt_set;
    logic [NUM_EVT-1:0] flg;
    logic               inea;
    logic               intr;
    logic               err;
    logic [DW-1:0]      cfg_rd;
    logic [DW-1:0]      mode;
    logic [DW-1:0]      csr0_rd;
    logic               running;

    always_ff @(posedge clk) begin
        if (!rst_n)                  sel_q <= '0;
        else if (reg_wr && reg_sel)  sel_q <= reg_wdata[AW-1:0];
    end

    assign data_wr = reg_wr && !reg_sel;
    assign csr0_wr = data_wr && (sel_q == '0);
    assign cfg_wr  = data_wr && (sel_q != '0) && (state_q == CS_STOPPED);

    lcsr_ctl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (csr0_wr),
        .cmd_bits     (reg_wdata[3:0]),
        .init_done_in (evt_init_done),
        .state_q      (state_q),
        .start_pend_q (start_pend),
        .init_start_q (init_start),
        .tx_poll_q    (tx_poll),
        .idon_set     (idon_set),
        .stop_cmd     (stop_cmd)
    );

    assign evt_set = {evt_babble, evt_carrier_lost, evt_rx_missed, evt_mem_err,
                      evt_rx_done, evt_tx_done, idon_set};

    lcsr_evt_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .csr0_wr (csr0_wr),
        .wdata   (reg_wdata),
        .evt_set (evt_set),
        .flg_q   (flg),
        .inea_q  (inea),
        .intr    (intr),
        .err     (err),
        .irq     (irq)
    );

    lcsr_cfg_regs #(
        .DW        (DW),
        .AW        (AW),
        .NUM_FILT  (NUM_FILT),
        .FILT_BASE (FILT_BASE),
        .CFG_W     (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .idx       (sel_q),
        .wdata     (reg_wdata),
        .stop_cmd  (stop_cmd),
        .init_addr (init_addr),
        .bus_cfg   (bus_cfg),
        .filt      (mc_filter),
        .mode      (mode),
        .rd_val    (cfg_rd)
    );

    assign running = (state_q == CS_RUNNING);
    assign tx_on   = running;
    assign rx_on   = running;
    assign promisc = mode[DW-1];

    always_comb begin
        csr0_rd = '0;
        csr0_rd[B_INIT] = (state_q == CS_INITIALIZING);
        csr0_rd[B_STRT] = running || start_pend;
        csr0_rd[B_STOP] = (state_q == CS_STOPPED);
        csr0_rd[B_TXON] = running;
        csr0_rd[B_RXON] = running;
        csr0_rd[B_INEA] = inea;
        csr0_rd[B_INTR] = intr;
        csr0_rd[B_FLG0 +: NUM_EVT] = flg;
        csr0_rd[B_ERR]  = err;
    end

    always_comb begin
        if (reg_sel)             reg_rdata = DW'(sel_q);
        else if (sel_q == '0)    reg_rdata = csr0_rd;
        else                     reg_rdata = cfg_rd;
    end

    AST_CFG_LOCKED_OUTSIDE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && sel_q != '0 && state_q != CS_STOPPED) |=> ($stable(init_addr) && $stable(mc_filter) && $stable(promisc))); // R12
    AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (sel_q == $past(reg_wdata[AW-1:0]))); // R1
    AST_RUN_EXCLUDES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_on |-> !csr0_rd[B_STOP]); // R6

endmodule

// File: tb/lan_csr_file_test.sv
`timescale 1ns/1ps
module lan_csr_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  ev = '0;
    logic        irq, tx_on, rx_on, init_start, tx_poll, promisc;
    logic [31:0] init_addr;
    logic [2:0]  bus_cfg;
    logic [63:0] mc_filter;

    always #4 clk = ~clk;

    lan_csr_file uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_init_done(ev[0]), .evt_tx_done(ev[1]), .evt_rx_done(ev[2]),
        .evt_mem_err(ev[3]), .evt_rx_missed(ev[4]), .evt_carrier_lost(ev[5]),
        .evt_babble(ev[6]), .irq(irq), .tx_on(tx_on), .rx_on(rx_on),
        .init_start(init_start), .tx_poll(tx_poll), .init_addr(init_addr),
        .bus_cfg(bus_cfg), .mc_filter(mc_filter), .promisc(promisc)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // requirement-level model
    int        m_st = 0;  // 0 stopped, 1 initializing, 2 idle, 3 running
    bit        m_pend = 0;
    bit [6:0]  m_flg = '0;
    bit        m_inea = 0;
    bit [15:0] m_lo = '0, m_hi = '0, m_mode = '0;
    bit [2:0]  m_cfg = '0;
    bit [15:0] m_filt [4] = '{default: '0};
    bit [3:0]  m_addr = '0;
    bit        e_poll = 0, e_istart = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [15:0] exp_csr0();
        bit [15:0] v = '0;
        v[0]    = (m_st == 1);
        v[1]    = (m_st == 3) || (m_st == 1 && m_pend);
        v[2]    = (m_st == 0);
        v[4]    = (m_st == 3);
        v[5]    = (m_st == 3);
        v[6]    = m_inea;
        v[7]    = |(m_flg & 7'b1011111);
        v[14:8] = m_flg;
        v[15]   = |(m_flg & 7'b1111000);
        return v;
    endfunction

    function automatic bit [15:0] exp_rd(input bit [3:0] idx);
        case (idx)
            4'd0:  return exp_csr0();
            4'd1:  return m_lo;
            4'd2:  return m_hi;
            4'd3:  return {13'd0, m_cfg};
            4'd8:  return m_filt[0];
            4'd9:  return m_filt[1];
            4'd10: return m_filt[2];
            4'd11: return m_filt[3];
            4'd15: return m_mode;
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_step(input bit wr, input bit sel, input bit [15:0] d, input bit [6:0] e);
        bit dwr, c0, stp, iw, sw, tw, idon;
        int nst;
        bit npend;
        bit [6:0] clr;
        dwr = wr && !sel;
        c0  = dwr && (m_addr == 0);
        stp = c0 && d[2];
        iw  = c0 && d[0];
        sw  = c0 && d[1];
        tw  = c0 && d[3];
        idon = 0; nst = m_st; npend = m_pend;
        if (stp) begin nst = 0; npend = 0; end
        else if (m_st == 1) begin
            if (e[0]) begin idon = 1; nst = (m_pend || sw) ? 3 : 2; npend = 0; end
            else if (sw) npend = 1;
        end else if (iw) begin nst = 1; npend = sw; end
        else if (sw && m_st != 3) nst = 3;
        e_istart = (nst == 1) && (m_st != 1);
        e_poll   = tw && !stp && (m_st == 3);
        if (dwr && m_addr != 0 && m_st == 0) begin
            case (m_addr)
                4'd1: m_lo = d;
                4'd2: m_hi = d;
                4'd3: m_cfg = d[2:0];
                4'd8: m_filt[0] = d;
                4'd9: m_filt[1] = d;
                4'd10: m_filt[2] = d;
                4'd11: m_filt[3] = d;
                4'd15: m_mode = d;
                default: ;
            endcase
        end
        if (stp) m_cfg = '0;
        clr = c0 ? (d[14:8] | (d[15] ? 7'b1111000 : 7'b0)) : 7'b0;
        m_flg = (m_flg & ~clr) | {e[6:1], idon};
        if (c0) m_inea = d[6];
        if (wr && sel) m_addr = d[3:0];
        m_st = nst;
        m_pend = npend;
    endtask

    // one bus cycle; inputs driven after a falling edge, results sampled after the next one
    task automatic cyc(input bit wr, input bit sel, input bit [15:0] d, input bit [6:0] e);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; ev = e;
        model_step(wr, sel, d, e);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 0; reg_sel = 0; reg_wdata = '0; ev = '0;
        #1;
        chk("R7 tx_poll", tx_poll, e_poll);
        chk("R5 init_start", init_start, e_istart);
        chk(m_addr == 0 ? "R10 csr0 read" : "R12 cfg read", reg_rdata, exp_rd(m_addr));
        chk("R11 irq", irq, m_inea && (|(m_flg & 7'b1011111)));
        chk("R6 tx_on/rx_on", {tx_on, rx_on}, {2{m_st == 3}});
    endtask

    task automatic wa(input bit [3:0] n);
        cyc(1, 1, {12'd0, n}, '0);
    endtask
    task automatic wd(input bit [15:0] d);
        cyc(1, 0, d, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        chk("R2 csr0 reset", reg_rdata, 16'h0004);
        chk("R2 outputs reset", {irq, tx_on, rx_on, init_start, tx_poll}, 5'b0);
        reg_sel = 1; #1;
        chk("R1 address readback reset", reg_rdata, 16'h0000);
        reg_sel = 0;
        wa(4'd3);
        chk("R2 csr3 reset", reg_rdata, 16'h0000);

        // R12 configuration while stopped
        wa(4'd1); wd(16'h1234);
        wa(4'd2); wd(16'h00AB);
        wa(4'd3); wd(16'hFFFF);
        chk("R12 csr3 width", reg_rdata, 16'h0007);
        for (int k = 0; k < 4; k++) begin wa(4'(8 + k)); wd(16'hA000 + 16'(k)); end
        wa(4'd15); wd(16'h8000);
        @(negedge clk); reg_sel = 1; #1;
        chk("R1 address readback", reg_rdata, 16'h000F);
        reg_sel = 0;
        chk("R12 init_addr", init_addr, 32'h00AB1234);
        chk("R12 bus_cfg", bus_cfg, 3'd7);
        chk("R12 mc_filter", mc_filter, 64'hA003A002A001A000);
        chk("R12 promisc", promisc, 1'b1);

        // R4 stop clears bus configuration
        wa(4'd0); wd(16'h0004);
        chk("R4 bus_cfg after stop", bus_cfg, 3'd0);
        chk("R4 init_addr kept", init_addr, 32'h00AB1234);

        // R5 init then done
        wd(16'h0001);
        chk("R5 init reads", reg_rdata, 16'h0001);
        cyc(0, 0, '0, 7'b0000001);
        chk("R5 init done", reg_rdata, 16'h0180);

        // R6 start with interrupt enable
        wd(16'h0042);
        chk("R6 running word", reg_rdata, 16'h01F2);
        chk("R11 irq raised", irq, 1'b1);

        // R12 locked while running
        wa(4'd1); wd(16'h5555);
        chk("R12 write ignored when running", init_addr, 32'h00AB1234);
        wa(4'd0);

        // R7 transmit demand, R8 zero writes
        wd(16'h004A);
        chk("R7 demand reads zero", reg_rdata, 16'h01F2);
        wd(16'h0040);
        chk("R8 zero command bits", reg_rdata, 16'h01F2);

        // R9 clear init-done
        wd(16'h0140);
        chk("R9 idon cleared", reg_rdata, 16'h0072);
        chk("R11 irq dropped", irq, 1'b0);

        // R10 carrier excluded from summary interrupt
        cyc(0, 0, '0, 7'b0100000);
        chk("R10 carrier sets err only", reg_rdata, 16'hA072);
        chk("R10 carrier no irq", irq, 1'b0);
        cyc(0, 0, '0, 7'b1000000);
        chk("R10 babble word", reg_rdata, 16'hE0F2);
        wd(16'h8040);
        chk("R9 err clears group", reg_rdata, 16'h0072);

        // R9 set wins over clear
        cyc(1, 0, 16'h0440, 7'b0000100);
        chk("R9 set wins", reg_rdata, 16'h04F2);
        wd(16'h0440);

        // R3 stop with init
        wd(16'h0005);
        chk("R3 stop plus init", reg_rdata, 16'h0004);
        cyc(0, 0, '0, 7'b0000001);
        chk("R5 done ignored when stopped", reg_rdata, 16'h0004);

        // R5 init with start pending
        wd(16'h0003);
        chk("R5 pending start", reg_rdata, 16'h0003);
        cyc(0, 0, '0, 7'b0000001);
        chk("R5 start after init", reg_rdata, 16'h01B2);
        wd(16'h0008);
        wd(16'h0004);
        wd(16'h0008);
        chk("R7 demand ignored when stopped", tx_poll, 1'b0);

        // random phase
        for (int i = 0; i < 1500; i++) begin
            int r;
            bit [15:0] d;
            bit [6:0] e;
            r = int'($urandom % 8);
            d = 16'($urandom);
            e = 7'($urandom) & 7'($urandom) & 7'($urandom);
            if (r < 2) begin
                d = ($urandom % 2 == 0) ? 16'd0 : {12'd0, d[3:0]};
                cyc(1, 1, d, e);
            end else if (r < 6) begin
                if ($urandom % 5 != 0) d[2] = 1'b0;
                cyc(1, 0, d, e);
            end else begin
                cyc(0, 0, '0, e);
            end
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule